// File: doc/BRIEF.md
# PIN Authentication Controller with Failure Throttling

This block decides which roles of a storage security subsystem are currently authenticated. It keeps one 256-bit PIN digest per role and never holds a plaintext PIN. An authenticate command sends the entered PIN, with its unused bytes zeroed, to an external hash engine. The returned digest is compared with the stored digest over all 256 bits. A match sets that role's authenticated flag. A mismatch clears the flag and starts a fixed penalty window. While the window runs, every command is answered busy.

A set-PIN command replaces a role's digest with the hash of a new PIN. The command must come from a role that is already authenticated, and it may target only that same role. PINs shorter than the minimum length or longer than the maximum length are rejected. A zeroise command wipes every stored digest and clears every authenticated flag. The hash engine is reached through a simple request/response pair and lies outside the block.

Role index encoding: 0 is the security-ID role, 1 is the erase role, and 2+k is band role k, for k from 0 to NUM_BAND. The default NUM_BAND of 64 gives 67 roles.

Top module: `pin_auth_ctrl`

## Requirements
- R1: After reset no response and no hash request is pending, all authenticated flags are 0, and every role holds the INIT_DIGEST parameter as its stored digest.
- R2: Opcodes are 0 = authenticate, 1 = set-PIN, 2 = zeroise and 3 = reserved. A command whose role index is NUM_BAND+3 or more, or whose opcode is 3, is answered with code 7 (reject) and has no other effect.
- R3: For authenticate and set-PIN, a length above MAX_LEN (32) is answered with code 4. No hash request is made for it.
- R4: An accepted command sends a single hash request. It carries the PIN with byte i at bits 8i+7:8i, every byte at or beyond the length forced to 0x00, and the length itself. Any byte value 0x00 to 0xFF is a legal PIN byte.
- R5: When the returned digest equals the role's stored digest, authenticate answers code 0 and sets only that role's flag. All other flags are unchanged.
- R6: On a digest mismatch, authenticate answers code 1, clears that role's flag and starts the penalty window.
- R7: Take the clock edge that issues the code-1 response as edge E. Every command sampled at edges E+1 through E+CLK_HZ*LOCK_SECONDS is answered with code 2 (busy) and has no other effect. The next edge accepts commands again.
- R8: A command sampled while a hash result is still awaited is answered with code 2 and has no effect.
- R9: Set-PIN from a role whose flag is 0 is answered with code 5.
- R10: Set-PIN whose target index differs from the requesting role is answered with code 6.
- R11: Set-PIN with a length below MIN_LEN (8) is answered with code 3. For set-PIN the checks apply in this order: length over maximum, then not authenticated, then wrong target, then too short.
- R12: A successful set-PIN answers code 0 and stores the returned digest for that role. The old PIN then fails and the new one succeeds.
- R13: Zeroise answers code 0, sets every stored digest to zero and clears every flag.
- R14: The comparison covers all 256 digest bits. A difference confined to the lowest byte, or to the highest byte, still fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Opcode (R2) |
| cmd_role | input | ROLE_W | Requesting role index |
| cmd_target | input | ROLE_W | Role whose PIN set-PIN changes |
| cmd_len | input | LEN_W | PIN length in bytes |
| cmd_pin | input | MAX_LEN*8 | PIN bytes, byte 0 lowest |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 3 | Response code |
| hreq_valid | output | 1 | Hash request strobe |
| hreq_pin | output | MAX_LEN*8 | Masked PIN to hash |
| hreq_len | output | LEN_W | Length to hash |
| hrsp_valid | input | 1 | Hash result strobe |
| hrsp_digest | input | 256 | Hash result |
| auth_flags | output | NUM_BAND+3 | Per-role authenticated flags |

## Verification
The bench targets the edges of the penalty window. It places one command on the last busy edge and another on the first free edge. A counter that is off by one would answer busy where the window should already have ended, or would let an attempt through early. Digests that differ only in their top byte or only in their bottom byte catch a comparator that looks at part of the word. Stray bytes past the PIN length catch a design that leaves them in the hash request, which would make a correct PIN fail. Other stimuli catch a set-PIN path that writes to the target role without checking ownership, and a zeroise that clears the flags but leaves old digests usable. A command issued while a hash is in flight checks that the design does not start a second hash or lose its pending role.

// File: rtl/pin_auth_pkg.sv
package pin_auth_pkg;

    localparam int DIGEST_W = 256;

    typedef enum logic [1:0] {
        OP_AUTH = 2'd0,
        OP_SET  = 2'd1,
        OP_ZERO = 2'd2,
        OP_RSVD = 2'd3
    } pa_op_e;

    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_FAIL    = 3'd1,
        RC_BUSY    = 3'd2,
        RC_SHORT   = 3'd3,
        RC_LONG    = 3'd4,
        RC_DENIED  = 3'd5,
        RC_NOT_OWN = 3'd6,
        RC_REJECT  = 3'd7
    } pa_rc_e;

    typedef enum logic {
        FSM_IDLE = 1'b0,
        FSM_HASH = 1'b1
    } pa_fsm_e;

endpackage

// File: rtl/pin_len_check.sv
module pin_len_check #(
    parameter int LEN_W   = 6,
    parameter int MIN_LEN = 8,
    parameter int MAX_LEN = 32,
    localparam int PIN_W  = MAX_LEN * 8
) (
    input  logic [LEN_W-1:0] len,
    input  logic [PIN_W-1:0] pin_in,
    output logic             too_long,
    output logic             too_short,
    output logic [PIN_W-1:0] pin_masked
);
    assign too_long  = len > LEN_W'(MAX_LEN);
    assign too_short = len < LEN_W'(MIN_LEN);

    for (genvar b = 0; b < MAX_LEN; b++) begin : g_byte
        localparam logic [LEN_W-1:0] BIDX = LEN_W'(b);
        assign pin_masked[b*8 +: 8] = (BIDX < len) ? pin_in[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/pin_digest_store.sv
module pin_digest_store #(
    parameter int NUM_ROLES = 67,
    parameter int ROLE_W    = 7,
    parameter int DIGEST_W  = 256,
    parameter logic [DIGEST_W-1:0] INIT = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ROLE_W-1:0]   wr_idx,
    input  logic [DIGEST_W-1:0] wr_data,
    input  logic                clr_all,
    input  logic [ROLE_W-1:0]   rd_idx,
    output logic [DIGEST_W-1:0] rd_data
);
    logic [NUM_ROLES-1:0][DIGEST_W-1:0] slots;

    for (genvar r = 0; r < NUM_ROLES; r++) begin : g_role
        logic [DIGEST_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= INIT;
            else if (clr_all)
                slot_q <= '0;
            else if (wr_en && wr_idx == ROLE_W'(r))
                slot_q <= wr_data;
        end
        assign slots[r] = slot_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_ROLES; i++)
            if (rd_idx == ROLE_W'(i)) rd_data = slots[i];
    end
endmodule

// File: rtl/pin_lockout_timer.sv
module pin_lockout_timer #(
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] LOAD = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = LOAD;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign active = tmr_q.run;
endmodule

// File: rtl/pin_auth_ctrl.sv
module pin_auth_ctrl
    import pin_auth_pkg::*;
#(
    parameter int NUM_BAND     = 64,
    parameter int CLK_HZ       = 250_000_000,
    parameter int LOCK_SECONDS = 2,
    parameter int MIN_LEN      = 8,
    parameter int MAX_LEN      = 32,
    parameter int LEN_W        = 6,
    parameter logic [255:0] INIT_DIGEST = '0,
    localparam int NUM_ROLES   = NUM_BAND + 3,
    localparam int ROLE_W      = $clog2(NUM_ROLES + 1),
    localparam int PIN_W       = MAX_LEN * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [ROLE_W-1:0]    cmd_role,
    input  logic [ROLE_W-1:0]    cmd_target,
    input  logic [LEN_W-1:0]     cmd_len,
    input  logic [PIN_W-1:0]     cmd_pin,
    output logic                 rsp_valid,
    output logic [2:0]           rsp_code,
    output logic                 hreq_valid,
    output logic [PIN_W-1:0]     hreq_pin,
    output logic [LEN_W-1:0]     hreq_len,
    input  logic                 hrsp_valid,
    input  logic [255:0]         hrsp_digest,
    output logic [NUM_ROLES-1:0] auth_flags
);
    localparam logic [63:0] LOCK_CYC = 64'(CLK_HZ) * 64'(LOCK_SECONDS);
    localparam int CNT_W = $clog2(LOCK_CYC + 1);

    typedef struct packed {
        pa_fsm_e              fsm;
        logic                 is_set;
        logic [ROLE_W-1:0]    role;
        logic [NUM_ROLES-1:0] authed;
        logic                 rsp_v;
        pa_rc_e               rc;
        logic                 hreq_v;
        logic [PIN_W-1:0]     hpin;
        logic [LEN_W-1:0]     hlen;
    } st_t;

    st_t st_d, st_q;

    logic                too_long, too_short;
    logic [PIN_W-1:0]    pin_masked;
    logic [255:0]        stored;
    logic                wr_en, clr_all, lock_start, lock_active;
    logic                role_ok, digest_eq, fsm_idle;
    pa_op_e              op;

    pin_len_check #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_len (
        .len(cmd_len), .pin_in(cmd_pin),
        .too_long(too_long), .too_short(too_short), .pin_masked(pin_masked)
    );

    pin_digest_store #(
        .NUM_ROLES(NUM_ROLES), .ROLE_W(ROLE_W), .DIGEST_W(DIGEST_W), .INIT(INIT_DIGEST)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(st_q.role),
        .wr_data(hrsp_digest), .clr_all(clr_all), .rd_idx(st_q.role), .rd_data(stored)
    );

    pin_lockout_timer #(.CNT_W(CNT_W), .LOAD(CNT_W'(LOCK_CYC - 1))) u_lock (
        .clk(clk), .rst_n(rst_n), .start(lock_start), .active(lock_active)
    );

    assign op        = pa_op_e'(cmd_op);
    assign role_ok   = cmd_role < ROLE_W'(NUM_ROLES);
    assign digest_eq = ~|(hrsp_digest ^ stored);
    assign fsm_idle  = st_q.fsm == FSM_IDLE;

    always_comb begin
        st_d        = st_q;
        st_d.rsp_v  = 1'b0;
        st_d.hreq_v = 1'b0;
        wr_en       = 1'b0;
        clr_all     = 1'b0;
        lock_start  = 1'b0;

        if (st_q.fsm == FSM_HASH) begin
            if (hrsp_valid) begin
                st_d.fsm   = FSM_IDLE;
                st_d.rsp_v = 1'b1;
                if (st_q.is_set) begin
                    wr_en   = 1'b1;
                    st_d.rc = RC_OK;
                end else if (digest_eq) begin
                    st_d.authed[st_q.role] = 1'b1;
                    st_d.rc = RC_OK;
                end else begin
                    st_d.authed[st_q.role] = 1'b0;
                    st_d.rc    = RC_FAIL;
                    lock_start = 1'b1;
                end
            end else if (cmd_valid) begin
                st_d.rsp_v = 1'b1;
                st_d.rc    = RC_BUSY;
            end
        end else if (cmd_valid) begin
            st_d.rsp_v = 1'b1;
            if (lock_active) begin
                st_d.rc = RC_BUSY;
            end else if (!role_ok || op == OP_RSVD) begin
                st_d.rc = RC_REJECT;
            end else if (op == OP_ZERO) begin
                clr_all     = 1'b1;
                st_d.authed = '0;
                st_d.rc     = RC_OK;
            end else if (too_long) begin
                st_d.rc = RC_LONG;
            end else if (op == OP_SET && !st_q.authed[cmd_role]) begin
                st_d.rc = RC_DENIED;
            end else if (op == OP_SET && cmd_target != cmd_role) begin
                st_d.rc = RC_NOT_OWN;
            end else if (op == OP_SET && too_short) begin
                st_d.rc = RC_SHORT;
            end else begin
                st_d.rsp_v  = 1'b0;
                st_d.fsm    = FSM_HASH;
                st_d.is_set = (op == OP_SET);
                st_d.role   = cmd_role;
                st_d.hreq_v = 1'b1;
                st_d.hpin   = pin_masked;
                st_d.hlen   = cmd_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rsp_v;
    assign rsp_code   = st_q.rc;
    assign hreq_valid = st_q.hreq_v;
    assign hreq_pin   = st_q.hpin;
    assign hreq_len   = st_q.hlen;
    assign auth_flags = st_q.authed;
endmodule

// File: rtl/pin_auth_ctrl_chk.sv
module pin_auth_ctrl_chk #(
    parameter int NUM_ROLES = 67
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [1:0]           cmd_op,
    input logic                 rsp_valid,
    input logic [2:0]           rsp_code,
    input logic                 hreq_valid,
    input logic [NUM_ROLES-1:0] auth_flags,
    input logic                 lock_active,
    input logic                 fsm_idle
);
    AST_FAIL_STARTS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd1) |-> lock_active); // R6

    AST_NO_HASH_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        hreq_valid |-> !$past(lock_active)); // R7

    AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd2) |-> $past(cmd_valid)); // R8

    AST_ONE_HASH_PER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        hreq_valid |=> !hreq_valid); // R4

    AST_SINGLE_NEW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(auth_flags & ~$past(auth_flags))); // R5

    AST_FLAG_RISE_IS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (|(auth_flags & ~$past(auth_flags))) |-> (rsp_valid && rsp_code == 3'd0)); // R5

    AST_ZERO_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd0 && $past(cmd_valid && cmd_op == 2'd2 && fsm_idle))
        |-> (auth_flags == '0)); // R13
endmodule

bind pin_auth_ctrl pin_auth_ctrl_chk #(.NUM_ROLES(NUM_ROLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .hreq_valid(hreq_valid),
    .auth_flags(auth_flags), .lock_active(lock_active), .fsm_idle(fsm_idle)
);

// File: tb/pin_auth_ctrl_tb.sv
module pin_auth_ctrl_tb;
    localparam int CLK_HZ = 20;
    localparam int LOCK_S = 2;
    localparam int L      = CLK_HZ * LOCK_S;
    localparam int NR     = 67;

    function automatic logic [255:0] mkpin(input logic [7:0] seed);
        logic [255:0] p;
        for (int i = 0; i < 32; i++) p[i*8 +: 8] = seed + 8'(i * 29);
        return p;
    endfunction

    function automatic logic [255:0] maskp(input logic [255:0] p, input int len);
        logic [255:0] m;
        for (int i = 0; i < 32; i++) m[i*8 +: 8] = (i < len) ? p[i*8 +: 8] : 8'h00;
        return m;
    endfunction

    function automatic logic [255:0] fh(input logic [255:0] p, input logic [5:0] len);
        return p ^ {32{8'hC3}} ^ {len, 250'b0};
    endfunction

    localparam logic [255:0] INIT_D = fh(maskp(mkpin(8'h11), 8), 6'd8);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [6:0] cmd_role = '0, cmd_target = '0;
    logic [5:0] cmd_len = '0;
    logic [255:0] cmd_pin = '0;
    logic rsp_valid, hreq_valid;
    logic [2:0] rsp_code;
    logic [255:0] hreq_pin;
    logic [5:0] hreq_len;
    logic hrsp_valid = 1'b0;
    logic [255:0] hrsp_digest = '0;
    logic [NR-1:0] auth_flags;
    logic [255:0] last_req = '0;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pin_auth_ctrl #(.CLK_HZ(CLK_HZ), .LOCK_SECONDS(LOCK_S), .INIT_DIGEST(INIT_D)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_role(cmd_role), .cmd_target(cmd_target), .cmd_len(cmd_len), .cmd_pin(cmd_pin),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .hreq_valid(hreq_valid),
        .hreq_pin(hreq_pin), .hreq_len(hreq_len), .hrsp_valid(hrsp_valid),
        .hrsp_digest(hrsp_digest), .auth_flags(auth_flags)
    );

    always @(posedge clk) begin
        hrsp_valid <= hreq_valid;
        if (hreq_valid) begin
            hrsp_digest <= fh(hreq_pin, hreq_len);
            last_req    <= hreq_pin;
        end
    end

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [6:0] role, input logic [6:0] tgt,
                          input logic [5:0] len, input logic [255:0] pin,
                          output logic [2:0] code);
        int n;
        cmd_valid = 1'b1; cmd_op = op; cmd_role = role; cmd_target = tgt;
        cmd_len = len; cmd_pin = pin;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        code = rsp_valid ? rsp_code : 3'bxxx;
    endtask

    typedef struct packed {
        logic [1:0] op;
        logic [6:0] role;
        logic [6:0] tgt;
        logic [5:0] len;
        logic [7:0] seed;
        logic [2:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{2'd0, 7'd0,  7'd0, 6'd8,  8'h11, 3'd0, 4'd5},  // R5 role 0 default PIN
        '{2'd0, 7'd70, 7'd0, 6'd8,  8'h11, 3'd7, 4'd2},  // R2 role out of range
        '{2'd3, 7'd0,  7'd0, 6'd8,  8'h11, 3'd7, 4'd2},  // R2 reserved opcode
        '{2'd0, 7'd0,  7'd0, 6'd33, 8'h11, 3'd4, 4'd3},  // R3 auth too long
        '{2'd1, 7'd1,  7'd1, 6'd8,  8'h22, 3'd5, 4'd9},  // R9 not authenticated
        '{2'd1, 7'd0,  7'd1, 6'd8,  8'h22, 3'd6, 4'd10}, // R10 other role
        '{2'd1, 7'd0,  7'd0, 6'd7,  8'h22, 3'd3, 4'd11}, // R11 too short
        '{2'd1, 7'd0,  7'd0, 6'd40, 8'h22, 3'd4, 4'd3},  // R3 set too long
        '{2'd1, 7'd0,  7'd0, 6'd32, 8'h33, 3'd0, 4'd12}, // R12 new PIN
        '{2'd0, 7'd2,  7'd0, 6'd8,  8'h11, 3'd0, 4'd1},  // R1 first band default
        '{2'd0, 7'd66, 7'd0, 6'd8,  8'h11, 3'd0, 4'd1},  // R1 last band default
        '{2'd0, 7'd0,  7'd0, 6'd32, 8'h33, 3'd0, 4'd12}  // R12 new PIN works
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] c;
        logic [255:0] p;
        logic [NR-1:0] ef;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid", 256'(rsp_valid), 256'd0);
        chk("R1 hreq_valid", 256'(hreq_valid), 256'd0);
        chk("R1 flags", 256'(auth_flags), 256'd0);

        for (int i = 0; i < 12; i++) begin
            do_cmd(VEC[i].op, VEC[i].role, VEC[i].tgt, VEC[i].len, mkpin(VEC[i].seed), c);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), 256'(c), 256'(VEC[i].exp));
        end
        ef = '0; ef[0] = 1'b1; ef[2] = 1'b1; ef[66] = 1'b1;
        chk("R5 flags after table", 256'(auth_flags), 256'(ef));

        // R4: bytes past the length are garbage but must not reach the hash
        p = mkpin(8'h11);
        for (int b = 8; b < 32; b++) p[b*8 +: 8] = 8'hEE;
        do_cmd(2'd0, 7'd1, 7'd1, 6'd8, p, c);
        chk("R4 masked auth code", 256'(c), 256'd0);
        chk("R4 request bytes", last_req, maskp(p, 8));
        chk("R4 flag set", 256'(auth_flags[1]), 256'd1);

        // R8: zeroise issued while a hash is pending
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_role = 7'd2; cmd_len = 6'd8; cmd_pin = mkpin(8'h11);
        @(negedge clk);
        cmd_op = 2'd2; cmd_role = 7'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R8 busy during hash", {rsp_valid, rsp_code}, {1'b1, 3'd2});
        @(negedge clk);
        chk("R8 pending auth completes", {rsp_valid, rsp_code}, {1'b1, 3'd0});
        chk("R8 flags kept", 256'(auth_flags[1]), 256'd1);

        // R6 R7 R12: old PIN fails, window boundaries
        do_cmd(2'd0, 7'd0, 7'd0, 6'd8, mkpin(8'h11), c);
        chk("R12 old PIN rejected", 256'(c), 256'd1);
        chk("R6 flag cleared", 256'(auth_flags[0]), 256'd0);
        repeat (L - 1) @(negedge clk);
        do_cmd(2'd0, 7'd0, 7'd0, 6'd32, mkpin(8'h33), c);
        chk("R7 last busy edge", 256'(c), 256'd2);
        chk("R7 busy has no effect", 256'(auth_flags[0]), 256'd0);
        do_cmd(2'd0, 7'd0, 7'd0, 6'd32, mkpin(8'h33), c);
        chk("R7 first free edge", 256'(c), 256'd0);
        chk("R7 flag after window", 256'(auth_flags[0]), 256'd1);

        // R14: single-byte digest differences at both ends
        do_cmd(2'd1, 7'd2, 7'd2, 6'd32, mkpin(8'h44), c);
        chk("R12 set band0", 256'(c), 256'd0);
        p = mkpin(8'h44); p[255:248] = p[255:248] ^ 8'h01;
        do_cmd(2'd0, 7'd2, 7'd2, 6'd32, p, c);
        chk("R14 top byte differs", 256'(c), 256'd1);
        repeat (L + 2) @(negedge clk);
        p = mkpin(8'h44); p[7:0] = p[7:0] ^ 8'h80;
        do_cmd(2'd0, 7'd2, 7'd2, 6'd32, p, c);
        chk("R14 low byte differs", 256'(c), 256'd1);
        repeat (L + 2) @(negedge clk);
        do_cmd(2'd0, 7'd2, 7'd2, 6'd32, mkpin(8'h44), c);
        chk("R14 exact match", 256'(c), 256'd0);

        // R13: zeroise wipes flags and digests
        do_cmd(2'd2, 7'd0, 7'd0, 6'd0, '0, c);
        chk("R13 zeroise code", 256'(c), 256'd0);
        chk("R13 flags cleared", 256'(auth_flags), 256'd0);
        do_cmd(2'd0, 7'd66, 7'd0, 6'd8, mkpin(8'h11), c);
        chk("R13 default PIN gone", 256'(c), 256'd1);
        repeat (L + 2) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule